// File: doc/BRIEF.md
# Pulse Timing Measurement Unit

This block turns a square wave from an external voltage-to-frequency or voltage-to-pulse-width converter into a 16-bit number. The input pin is asynchronous. It passes through a synchronizer, and the edges it yields are measured in one of three ways. The first way times the active part of one input cycle, either the high part or the low part. The second way times one full input cycle, from rising edge to rising edge. The third way counts rising edges during a gate window of fixed length. A gate of 2^23 cycles of a 10 MHz clock lasts 0.8388608 s.

The two time modes count ticks from a prescaled timebase, so their results grow as the input frequency falls. The edge-count mode takes the same time for every conversion, and its result falls as the input frequency falls. A start pulse begins one measurement. When auto-repeat is held, the block re-arms itself after every result. Each result is marked by a one-cycle valid strobe. A result that does not fit in 16 bits is clamped and flagged.

Top module: `pulse_meter`

## Requirements
- R1: While reset is high and after it is released, `result` is 0, and `result_vld` and `overflow` are 0.
- R2: With `mode_sel` = 0 (on-time) and `pol_low` = 0, the result is the length of one high phase of the input, in ticks. A tick is TICK_DIV clock cycles, and a partial tick is dropped.
- R3: With `mode_sel` = 0 and `pol_low` = 1, the result is the length of one low phase of the input, in ticks.
- R4: With `mode_sel` = 1 or 3 (period), the result is the time from one rising input edge to the next, in ticks.
- R5: With `mode_sel` = 2 (edge count), the result is the number of rising input edges seen during the GATE_CYCLES clock cycles that follow the accepted start. The default is 2^23 cycles.
- R6: A time mode ignores any phase already in progress when the measurement starts. Timing begins at the next qualifying edge.
- R7: A count that would pass 0xFFFF holds at 0xFFFF and sets `overflow`. A count that ends at exactly 0xFFFF leaves `overflow` clear.
- R8: `result_vld` is high for exactly one cycle per result. `result` and `overflow` keep their value until the next result.
- R9: With `auto_rep` high, a new measurement is armed in the cycle of each strobe. With `auto_rep` low, each accepted start gives exactly one strobe.
- R10: While a measurement runs, `start` pulses and changes to `mode_sel` or `pol_low` have no effect on it. Mode and polarity are captured when the measurement is launched.
- R11: With TICK_DIV > 1, a time-mode result equals floor(duration in clock cycles / TICK_DIV).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous square-wave input |
| mode_sel | input | 2 | 0 on-time, 1 or 3 period, 2 edge count |
| pol_low | input | 1 | On-time mode: 1 times the low phase, 0 times the high phase |
| start | input | 1 | Launches a measurement when the block is idle |
| auto_rep | input | 1 | Re-arm after each result |
| result | output | CNT_W | Measured value |
| result_vld | output | 1 | One-cycle strobe marking a new result |
| overflow | output | 1 | The result saturated |

## Verification
The tick that would push the counter past 0xFFFF can land in the same cycle as the edge that closes a time measurement. The design has to decide in that one cycle whether the overflow flag goes with the result. The bench provokes this by driving high phases of exactly 65535 and then 65536 clock cycles with the prescaler set to one. The first must give 0xFFFF with `overflow` clear, and the second 0xFFFF with `overflow` set.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    MODE_ONTIME     = 2'd0,
    MODE_PERIOD     = 2'd1,
    MODE_COUNT      = 2'd2,
    MODE_PERIOD_ALT = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_TIME = 2'd2,
    ST_GATE = 2'd3
  } state_t;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/pm_tick.sv
module pm_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc;

  assign tick = en && (pc == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  pc <= '0;
    else if (en)     pc <= (pc == LAST) ? '0 : pc + 1'b1;
  end

  // R11: phase counter stays inside the divide range
  assert_tick_range_R11: assert property (@(posedge clk) disable iff (rst)
    pc <= LAST);
endmodule

// File: rtl/pm_sat_cnt.sv
module pm_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val_nxt,
  output logic         ovf_nxt
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] val;
  logic         ovf;

  always_comb begin
    val_nxt = val;
    ovf_nxt = ovf;
    if (inc) begin
      if (val == TOP) ovf_nxt = 1'b1;
      else            val_nxt = val + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val <= '0;
      ovf <= 1'b0;
    end else begin
      val <= val_nxt;
      ovf <= ovf_nxt;
    end
  end

  // R7: the sticky flag is only ever set with the count pinned at its top
  assert_ovf_saturated_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (val == TOP));
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int GATE_CYCLES = 8388608
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             auto_rep,
  input  logic [1:0]       mode_sel,
  input  logic             pol_low,
  input  logic             rise,
  input  logic             fall,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             ovf_nxt,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             tick_clr,
  output logic             tick_en,
  output logic [CNT_W-1:0] result,
  output logic             result_vld,
  output logic             ovf
);
  localparam int GW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYCLES - 1);

  state_t        st, st_n;
  mode_t         mode_q, mode_n;
  logic          pol_q, pol_n;
  logic [GW-1:0] gcnt, gcnt_n;
  logic          fin, launch, period_like;
  logic          begin_edge, end_edge;

  always_comb begin
    period_like = (mode_q == MODE_PERIOD) || (mode_q == MODE_PERIOD_ALT);
    if (period_like) begin
      begin_edge = rise;
      end_edge   = rise;
    end else if (pol_q) begin
      begin_edge = fall;
      end_edge   = rise;
    end else begin
      begin_edge = rise;
      end_edge   = fall;
    end
  end

  always_comb begin
    st_n     = st;
    mode_n   = mode_q;
    pol_n    = pol_q;
    gcnt_n   = gcnt;
    fin      = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    tick_clr = 1'b0;
    tick_en  = 1'b0;
    case (st)
      ST_ARM: begin
        if (begin_edge) begin
          st_n     = ST_TIME;
          tick_clr = 1'b1;
          cnt_clr  = 1'b1;
        end
      end
      ST_TIME: begin
        tick_en = 1'b1;
        cnt_inc = tick;
        if (end_edge) fin = 1'b1;
      end
      ST_GATE: begin
        cnt_inc = rise;
        gcnt_n  = gcnt + 1'b1;
        if (gcnt == GATE_LAST) fin = 1'b1;
      end
      default: ;
    endcase
    launch = ((st == ST_IDLE) && start) || (fin && auto_rep);
    if (fin && !auto_rep) st_n = ST_IDLE;
    if (launch) begin
      mode_n  = mode_t'(mode_sel);
      pol_n   = pol_low;
      gcnt_n  = '0;
      cnt_clr = 1'b1;
      st_n    = (mode_t'(mode_sel) == MODE_COUNT) ? ST_GATE : ST_ARM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mode_q     <= MODE_ONTIME;
      pol_q      <= 1'b0;
      gcnt       <= '0;
      result     <= '0;
      result_vld <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      st         <= st_n;
      mode_q     <= mode_n;
      pol_q      <= pol_n;
      gcnt       <= gcnt_n;
      result_vld <= fin;
      if (fin) begin
        result <= cnt_nxt;
        ovf    <= ovf_nxt;
      end
    end
  end

  // R8: strobe never lasts two cycles
  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    result_vld |=> !result_vld);

  // R7: a flagged result is always the clamped value
  assert_sat_value_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (result == {CNT_W{1'b1}}));

  // R9: a strobe only follows a cycle in which a measurement was running
  assert_vld_from_busy_R9: assert property (@(posedge clk) disable iff (rst)
    result_vld |-> ($past(st) != ST_IDLE));

  // R5: gate counter never runs past the window
  assert_gate_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GATE) |-> (gcnt <= GATE_LAST));

  // R10: captured mode is held while timing runs
  assert_mode_held_R10: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_TIME) && $past(st == ST_TIME) && !$past(fin)) |-> $stable(mode_q));
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter #(
  parameter int CNT_W       = 16,
  parameter int TICK_DIV    = 4,
  parameter int GATE_CYCLES = 8388608,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [1:0]       mode_sel,
  input  logic             pol_low,
  input  logic             start,
  input  logic             auto_rep,
  output logic [CNT_W-1:0] result,
  output logic             result_vld,
  output logic             overflow
);
  logic             rise, fall, tick;
  logic             cnt_clr, cnt_inc, tick_clr, tick_en;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ovf_nxt;

  pm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sig_in), .rise(rise), .fall(fall)
  );

  pm_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(tick_clr), .en(tick_en), .tick(tick)
  );

  pm_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .val_nxt(cnt_nxt), .ovf_nxt(ovf_nxt)
  );

  pm_ctrl #(.CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .auto_rep(auto_rep),
    .mode_sel(mode_sel), .pol_low(pol_low), .rise(rise), .fall(fall),
    .tick(tick), .cnt_nxt(cnt_nxt), .ovf_nxt(ovf_nxt),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .tick_clr(tick_clr), .tick_en(tick_en),
    .result(result), .result_vld(result_vld), .ovf(overflow)
  );
endmodule

// File: tb/test_pulse_meter.sv
`timescale 1ns/1ps
module test_pulse_meter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd0;
  logic        pol_low = 1'b0;
  logic        start = 1'b0;
  logic        auto_rep = 1'b0;
  logic        gen_on = 1'b0;
  logic        gen_sig = 1'b0;
  logic        man_sig = 1'b0;
  logic        sig_in;
  int          hi_len = 10;
  int          lo_len = 10;
  logic [15:0] result, result_d4;
  logic        result_vld, overflow, vld_d4, ovf_d4;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;
  assign sig_in = gen_on ? gen_sig : man_sig;

  pulse_meter #(.CNT_W(16), .TICK_DIV(1), .GATE_CYCLES(1200)) i_pulse_meter (
    .clk(clk), .rst(rst), .sig_in(sig_in), .mode_sel(mode_sel), .pol_low(pol_low),
    .start(start), .auto_rep(auto_rep), .result(result), .result_vld(result_vld),
    .overflow(overflow)
  );

  pulse_meter #(.CNT_W(16), .TICK_DIV(4), .GATE_CYCLES(1200)) i_pulse_meter_div4 (
    .clk(clk), .rst(rst), .sig_in(sig_in), .mode_sel(mode_sel), .pol_low(pol_low),
    .start(start), .auto_rep(auto_rep), .result(result_d4), .result_vld(vld_d4),
    .overflow(ovf_d4)
  );

  initial begin
    forever begin
      if (gen_on) begin
        gen_sig = 1'b1;
        repeat (hi_len) @(negedge clk);
        gen_sig = 1'b0;
        repeat (lo_len) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_vld(input int limit, output bit got);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (result_vld) begin got = 1'b1; break; end
    end
  endtask

  task automatic set_wave(input int hi, input int lo);
    hi_len = hi; lo_len = lo; gen_on = 1'b1;
    repeat (450) @(negedge clk);
  endtask

  task automatic measure(input string req, input int exp);
    bit got;
    pulse_start();
    wait_vld(2000, got);
    check({req, " strobe seen"}, got, 1);
    check({req, " value"}, result, exp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 0);
    check("R1 vld in reset", result_vld, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 result after reset", result, 0);
    check("R1 ovf after reset", overflow, 0);
    check("R1 vld after reset", result_vld, 0);
  endtask

  task automatic t_ontime_high();
    mode_sel = 2'd0; pol_low = 1'b0;
    set_wave(37, 23);
    measure("R2 high phase", 37);
    check("R2 ovf clear", overflow, 0);
    @(negedge clk);
    check("R8 strobe one cycle", result_vld, 0);
    check("R8 result held", result, 37);
  endtask

  task automatic t_ontime_low();
    mode_sel = 2'd0; pol_low = 1'b1;
    measure("R3 low phase", 23);
    pol_low = 1'b0;
  endtask

  task automatic t_period();
    mode_sel = 2'd1;
    measure("R4 period mode1", 60);
    mode_sel = 2'd3;
    measure("R4 period mode3", 60);
    mode_sel = 2'd0;
  endtask

  task automatic t_partial();
    bit got;
    gen_on = 1'b0; man_sig = 1'b0; mode_sel = 2'd0; pol_low = 1'b0;
    repeat (10) @(negedge clk);
    man_sig = 1'b1;
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    man_sig = 1'b0;
    repeat (20) @(negedge clk);
    man_sig = 1'b1;
    repeat (15) @(negedge clk);
    man_sig = 1'b0;
    wait_vld(50, got);
    check("R6 strobe seen", got, 1);
    check("R6 partial phase discarded", result, 15);
  endtask

  task automatic t_prescale();
    bit got;
    mode_sel = 2'd0; pol_low = 1'b0;
    set_wave(103, 50);
    pulse_start();
    wait_vld(2000, got);
    check("R11 strobe seen", got, 1);
    check("R11 undivided", result, 103);
    check("R11 divided by 4", result_d4, 25);
    check("R11 div strobe aligned", vld_d4, 1);
  endtask

  task automatic t_count();
    int first;
    mode_sel = 2'd2;
    set_wave(15, 25);
    measure("R5 period 40", 30);
    first = result;
    set_wave(30, 30);
    measure("R5 period 60", 20);
    check("R5 lower freq fewer counts", (result < first) ? 1 : 0, 1);
    mode_sel = 2'd0;
  endtask

  task automatic t_ignore();
    bit got;
    int extra = 0;
    mode_sel = 2'd0; pol_low = 1'b0;
    set_wave(300, 100);
    pulse_start();
    repeat (150) @(negedge clk);
    mode_sel = 2'd2; pol_low = 1'b1;
    pulse_start();
    wait_vld(1000, got);
    check("R10 strobe seen", got, 1);
    check("R10 settings captured at launch", result, 300);
    for (int i = 0; i < 1400; i++) begin
      @(negedge clk);
      if (result_vld) extra++;
    end
    check("R9 one strobe per start", extra, 0);
    mode_sel = 2'd0; pol_low = 1'b0;
  endtask

  task automatic t_auto();
    bit got;
    int extra = 0;
    mode_sel = 2'd1;
    set_wave(20, 30);
    auto_rep = 1'b1;
    pulse_start();
    for (int k = 0; k < 3; k++) begin
      wait_vld(300, got);
      check("R9 auto strobe", got, 1);
      check("R9 auto value", result, 50);
    end
    auto_rep = 1'b0;
    wait_vld(300, got);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (result_vld) extra++;
    end
    check("R9 stops when auto cleared", extra, 0);
    mode_sel = 2'd0;
  endtask

  task automatic t_sat(input int len, input int exp_ovf);
    bit got;
    gen_on = 1'b0; man_sig = 1'b0; mode_sel = 2'd0; pol_low = 1'b0;
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (5) @(negedge clk);
    man_sig = 1'b1;
    repeat (len) @(negedge clk);
    man_sig = 1'b0;
    wait_vld(30, got);
    check("R7 strobe seen", got, 1);
    check("R7 clamped value", result, 16'hFFFF);
    check("R7 overflow flag", overflow, exp_ovf);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_ontime_high();
    t_ontime_low();
    t_period();
    t_partial();
    t_prescale();
    t_count();
    t_ignore();
    t_auto();
    t_sat(65535, 0);
    t_sat(65536, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule